// File: doc/BRIEF.md
# Video Control Signal Conditioner

This block sits on the pixel-clock side of a serial video link. It cleans up the three single-bit control signals that travel with the pixels: data enable, horizontal sync and vertical sync. Each signal passes through its own channel. Every channel has a short history register, an optional glitch filter and a transition budget. The budget caps how many times the conditioned output may change within a sliding window of 130 clock edges.

Data enable and horizontal sync share one set of rules. A 2-bit mode input can switch on a minimum-pulse filter for them, and each may change twice per window. Vertical sync is never filtered and may change only once per window. A change that would overrun a budget is not lost. It waits, and the output picks up the channel's current level as soon as the budget allows. When the link-ok input is low, all three outputs are forced. A select input decides whether they are driven low or frozen at their last value. Every channel has the same fixed latency, so the three outputs stay aligned with each other.

Top module: `synccond_top`

## Requirements
- R1: While reset is sampled high, all three outputs go low and every transition budget is refilled, so the first changes after reset are never deferred.
- R2: With cfgMode equal to 01, a data-enable or horizontal-sync level reaches its output only once the raw input has shown that level on at least 3 consecutive clock edges. A pulse of 1 or 2 clocks is dropped.
- R3: With cfgMode equal to 00, 10 or 11, data enable and horizontal sync are not filtered, and a 1-clock pulse is passed through.
- R4: outDe and outHs each make at most 2 transitions in any 130 consecutive clock edges, whatever the cfgMode value. Transitions forced by link-ok are not counted.
- R5: outVs makes at most 1 transition in any 130 consecutive clock edges.
- R6: cfgMode has no effect on the vertical-sync channel. A 1-clock vertical-sync pulse still produces an output change with cfgMode equal to 01.
- R7: A change that would exceed a budget is deferred. The output keeps its level and, on the first edge at which the budget has room, takes the channel's filtered level at that edge.
- R8: A raw level sampled at clock edge n (unfiltered, or already settled by the filter) appears on the output after edge n+2. This latency is the same in every mode, so simultaneous raw changes leave together.
- R9: When linkOk is sampled low with holdSel equal to 0, all outputs are low after that edge.
- R10: When linkOk is sampled low with holdSel equal to 1, all outputs keep their values. The history and filter keep running, and after linkOk returns the outputs follow the current filtered levels under the normal budgets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgMode | input | 2 | Filter mode: 01 enables the minimum-pulse filter, other codes disable it |
| linkOk | input | 1 | High when the link is locked and powered; low forces the outputs |
| holdSel | input | 1 | Forced-output choice: 0 drives low, 1 holds the last value |
| rawDe | input | 1 | Raw data enable |
| rawHs | input | 1 | Raw horizontal sync |
| rawVs | input | 1 | Raw vertical sync |
| outDe | output | 1 | Conditioned data enable |
| outHs | output | 1 | Conditioned horizontal sync |
| outVs | output | 1 | Conditioned vertical sync |

## Verification
Pulses of 1, 2 and 3 clocks are applied under each of the four cfgMode codes. This shows the filter threshold apart from the pass-through codes, and the unfiltered vertical channel apart from the other two. Fast toggling on data enable and vertical sync runs each budget dry, so the deferral timing and the pick-up of the current level at the window boundary are both checked. Simultaneous edges on all three inputs confirm the equal latency. The link-ok drops, once with each holdSel value while the inputs are moving, tell the drive-low choice apart from the freeze choice, and show that the output catches up afterwards.

// File: rtl/synccond_pkg.sv
package synccond_pkg;
  localparam int NUM_CH = 3;
  localparam int VS_CH = 2;
  localparam logic [1:0] FILTER_ON_CODE = 2'b01;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] take;   // channel may load its filtered level
    logic freeze;              // link down: outputs are forced
    logic zero;                // forced state is low (else hold)
  } strobe_t;
endpackage

// File: rtl/synccond_budget.sv
module synccond_budget #(
  parameter int WINDOW = 130,
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic avail
);
  localparam int TW = $clog2(WINDOW);

  logic [TW-1:0] timer [SLOTS];
  logic [SLOTS-1:0] idle;
  logic [SLOTS-1:0] pick;

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    assign idle[s] = (timer[s] == '0);
    always_ff @(posedge clk) begin
      if (rst) timer[s] <= '0;
      else if (fire && pick[s]) timer[s] <= TW'(WINDOW - 1);
      else if (!idle[s]) timer[s] <= timer[s] - 1'b1;
    end
  end

  assign avail = |idle;

  always_comb begin
    logic found;
    found = 1'b0;
    pick = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (idle[s] && !found) begin
        pick[s] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/synccond_ctrl.sv
module synccond_ctrl import synccond_pkg::*; #(
  parameter int WINDOW = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic linkOk,
  input  logic holdSel,
  input  logic [NUM_CH-1:0] wantChange,
  output strobe_t strobe
);
  logic [NUM_CH-1:0] avail;
  logic [NUM_CH-1:0] takeVec;

  assign takeVec = wantChange & avail & {NUM_CH{linkOk}};

  for (genvar g = 0; g < NUM_CH; g++) begin : gBud
    synccond_budget #(
      .WINDOW(WINDOW),
      .SLOTS((g == VS_CH) ? SLOW_BUDGET : FAST_BUDGET)
    ) uBudget (
      .clk(clk),
      .rst(rst),
      .fire(takeVec[g]),
      .avail(avail[g])
    );
  end

  always_comb begin
    strobe.take = takeVec;
    strobe.freeze = !linkOk;
    strobe.zero = !holdSel;
  end
endmodule

// File: rtl/synccond_path.sv
module synccond_path import synccond_pkg::*; #(
  parameter int MIN_PULSE = 3  // must be 2 or more
) (
  input  logic clk,
  input  logic rst,
  input  logic [1:0] cfgMode,
  input  logic [NUM_CH-1:0] rawIn,
  input  strobe_t strobe,
  output logic [NUM_CH-1:0] wantChange,
  output logic [NUM_CH-1:0] levelOut
);
  localparam int HIST = MIN_PULSE - 1;

  logic filterOn;
  logic [NUM_CH-1:0] candVec;

  assign filterOn = (cfgMode == FILTER_ON_CODE);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [HIST-1:0] hist;  // hist[0] is the newest sample

    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else begin
        hist[0] <= rawIn[g];
        for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
      end
    end

    if (g == VS_CH) begin : gRaw
      assign candVec[g] = hist[HIST-1];
    end else begin : gFilt
      logic heldLvl;
      logic settled;
      assign settled = (hist == {HIST{rawIn[g]}});
      assign candVec[g] = (filterOn && !settled) ? heldLvl : hist[HIST-1];
      always_ff @(posedge clk) begin
        if (rst) heldLvl <= 1'b0;
        else heldLvl <= candVec[g];
      end
    end
  end

  assign wantChange = candVec ^ levelOut;

  always_ff @(posedge clk) begin
    if (rst) levelOut <= '0;
    else if (strobe.freeze) begin
      if (strobe.zero) levelOut <= '0;
    end else begin
      levelOut <= (levelOut & ~strobe.take) | (candVec & strobe.take);
    end
  end
endmodule

// File: rtl/synccond_top.sv
module synccond_top import synccond_pkg::*; #(
  parameter int WINDOW = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1,
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic [1:0] cfgMode,
  input  logic linkOk,
  input  logic holdSel,
  input  logic rawDe,
  input  logic rawHs,
  input  logic rawVs,
  output logic outDe,
  output logic outHs,
  output logic outVs
);
  strobe_t strobe;
  logic [NUM_CH-1:0] wantChange;
  logic [NUM_CH-1:0] levelOut;

  synccond_ctrl #(
    .WINDOW(WINDOW),
    .FAST_BUDGET(FAST_BUDGET),
    .SLOW_BUDGET(SLOW_BUDGET)
  ) uCtrl (
    .clk(clk),
    .rst(rst),
    .linkOk(linkOk),
    .holdSel(holdSel),
    .wantChange(wantChange),
    .strobe(strobe)
  );

  synccond_path #(.MIN_PULSE(MIN_PULSE)) uPath (
    .clk(clk),
    .rst(rst),
    .cfgMode(cfgMode),
    .rawIn({rawVs, rawHs, rawDe}),
    .strobe(strobe),
    .wantChange(wantChange),
    .levelOut(levelOut)
  );

  assign {outVs, outHs, outDe} = levelOut;
endmodule

// File: rtl/synccond_chk.sv
module synccond_chk #(
  parameter int WINDOW = 130
) (
  input logic clk,
  input logic rst,
  input logic linkOk,
  input logic holdSel,
  input logic outDe,
  input logic outHs,
  input logic outVs
);
  localparam int AW = $clog2(WINDOW + 1) + 1;

  logic [2:0] outs;
  logic [2:0] prevOuts;
  logic prevLink;
  logic [AW-1:0] ageA [3];  // edges since the latest unforced change
  logic [AW-1:0] ageB [3];  // edges since the change before it

  assign outs = {outVs, outHs, outDe};

  function automatic logic [AW-1:0] satInc(input logic [AW-1:0] v);
    return (v >= AW'(WINDOW)) ? AW'(WINDOW) : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prevOuts <= '0;
      prevLink <= 1'b1;
    end else begin
      prevOuts <= outs;
      prevLink <= linkOk;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : gAge
    logic chg;
    assign chg = (outs[g] != prevOuts[g]) && prevLink;
    always_ff @(posedge clk) begin
      if (rst) begin
        ageA[g] <= AW'(WINDOW);
        ageB[g] <= AW'(WINDOW);
      end else if (chg) begin
        ageB[g] <= satInc(ageA[g]);
        ageA[g] <= AW'(1);
      end else begin
        ageA[g] <= satInc(ageA[g]);
        ageB[g] <= satInc(ageB[g]);
      end
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) $fell(rst) |-> outs == 3'b000);

  // R4
  de_budget_chk: assert property (@(posedge clk) disable iff (rst)
    gAge[0].chg |-> ageB[0] >= AW'(WINDOW));

  // R4
  hs_budget_chk: assert property (@(posedge clk) disable iff (rst)
    gAge[1].chg |-> ageB[1] >= AW'(WINDOW));

  // R5
  vs_budget_chk: assert property (@(posedge clk) disable iff (rst)
    gAge[2].chg |-> ageA[2] >= AW'(WINDOW));

  // R9
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!linkOk && !holdSel) |=> outs == 3'b000);

  // R10
  force_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!linkOk && holdSel) |=> $stable(outs));
endmodule

bind synccond_top synccond_chk #(.WINDOW(WINDOW)) uChk (
  .clk(clk),
  .rst(rst),
  .linkOk(linkOk),
  .holdSel(holdSel),
  .outDe(outDe),
  .outHs(outHs),
  .outVs(outVs)
);

// File: tb/synccond_top_test.sv
module synccond_top_test;
  localparam int WIN = 130;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfgMode = 2'b00;
  logic linkOk = 1'b0;
  logic holdSel = 1'b0;
  logic rawDe = 1'b0;
  logic rawHs = 1'b0;
  logic rawVs = 1'b0;
  logic outDe, outHs, outVs;

  synccond_top uut (
    .clk(clk), .rst(rst), .cfgMode(cfgMode), .linkOk(linkOk), .holdSel(holdSel),
    .rawDe(rawDe), .rawHs(rawHs), .rawVs(rawVs),
    .outDe(outDe), .outHs(outHs), .outVs(outVs)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] v;
    string tag;
  } item_t;
  item_t expQ[$];

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Stimulus settings applied at the next driven edge
  logic rstV = 1'b1;
  logic [1:0] cfgV = 2'b00;
  logic lkV = 1'b1;
  logic selV = 1'b0;
  string tagV = "R1";

  // Reference model state, per channel (0 de, 1 hs, 2 vs)
  logic p1[3], p2[3], stable[3], q[3];
  int runLen[3];
  int stamps[3][$];
  int edgeNo = 0;

  task automatic step(input logic [2:0] raw);
    item_t it;
    @(negedge clk);
    rst = rstV; cfgMode = cfgV; linkOk = lkV; holdSel = selV;
    {rawVs, rawHs, rawDe} = raw;
    for (int ch = 0; ch < 3; ch++) begin
      if (rstV) begin
        p1[ch] = 0; p2[ch] = 0; stable[ch] = 0; q[ch] = 0;
        runLen[ch] = 2;
        stamps[ch].delete();
      end else begin
        logic r;
        r = raw[ch];
        runLen[ch] = (r == p1[ch]) ? ((runLen[ch] < 3) ? runLen[ch] + 1 : 3) : 1;
        if (ch != 2 && cfgV == 2'b01) begin
          if (runLen[ch] >= 3) stable[ch] = r;
        end else begin
          stable[ch] = p2[ch];
        end
        if (lkV) begin
          while (stamps[ch].size() > 0 && edgeNo - stamps[ch][0] >= WIN)
            void'(stamps[ch].pop_front());
          if (stable[ch] != q[ch] && stamps[ch].size() < ((ch == 2) ? 1 : 2)) begin
            q[ch] = stable[ch];
            stamps[ch].push_back(edgeNo);
          end
        end else if (!selV) begin
          q[ch] = 0;
        end
        p2[ch] = p1[ch];
        p1[ch] = r;
      end
    end
    edgeNo++;
    it.v = {q[2], q[1], q[0]};
    it.tag = tagV;
    expQ.push_back(it);
  endtask

  task automatic hold(input logic [2:0] raw, input int n);
    for (int i = 0; i < n; i++) step(raw);
  endtask

  // Monitor: compare one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        compared++;
        if ({outVs, outHs, outDe} !== it.v) begin
          mismatched++;
          $display("FAIL %s: outputs {vs,hs,de} got %b expected %b at %0t",
                   it.tag, {outVs, outHs, outDe}, it.v, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #1000000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tagV = "R1"; rstV = 1; lkV = 1;
    hold(3'b000, 4);
    rstV = 0;
    hold(3'b000, 6);

    // R2: filter on, 2-clock DE pulse dropped, 3-clock HS pulse passed
    tagV = "R2"; cfgV = 2'b01;
    hold(3'b001, 2); hold(3'b000, 10);
    hold(3'b010, 3); hold(3'b000, 150);
    hold(3'b001, 1); hold(3'b000, 5);

    // R3: codes 00, 10, 11 pass 1-clock pulses
    tagV = "R3"; cfgV = 2'b00;
    hold(3'b001, 1); hold(3'b000, 140);
    cfgV = 2'b10;
    hold(3'b010, 1); hold(3'b000, 140);
    cfgV = 2'b11;
    hold(3'b001, 1); hold(3'b000, 140);

    // R4 R7: fast DE toggling drains the budget, deferred changes follow current level
    tagV = "R4 R7"; cfgV = 2'b00;
    for (int i = 0; i < 60; i++) begin
      hold(3'b001, 5); hold(3'b000, 5);
    end
    hold(3'b000, 150);
    cfgV = 2'b01;
    for (int i = 0; i < 40; i++) begin
      hold(3'b010, 4); hold(3'b000, 4);
    end
    hold(3'b000, 150);

    // R5 R6: VS unfiltered under code 01, one change per window
    tagV = "R5 R6"; cfgV = 2'b01;
    hold(3'b100, 1); hold(3'b000, 300);
    for (int i = 0; i < 15; i++) begin
      hold(3'b100, 20); hold(3'b000, 20);
    end
    hold(3'b000, 300);

    // R8: simultaneous edges leave together, both filter modes
    tagV = "R8"; cfgV = 2'b01;
    hold(3'b111, 10); hold(3'b111, 140);
    cfgV = 2'b00;
    hold(3'b000, 150);

    // R9: link down with drive-low choice
    tagV = "R9";
    hold(3'b111, 150);
    lkV = 0; selV = 0;
    hold(3'b111, 12);
    lkV = 1;
    hold(3'b111, 150);

    // R10: link down with hold choice while inputs move
    tagV = "R10"; selV = 1;
    lkV = 0;
    hold(3'b000, 8); hold(3'b101, 8); hold(3'b010, 8);
    lkV = 1;
    hold(3'b010, 150);
    hold(3'b000, 150);

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule